// File: doc/BRIEF.md
# Deserializer Bit-Slip Word Aligner

This block takes one serial receive lane and turns it into parallel words of a programmable width between 1 and 10 bits. Lanes in a wide link arrive with different skews. The block corrects the word boundary by adding whole bit-times of delay in front of the deserializer, one bit per slip request. Parallel logic downstream watches the words. It raises `align_req` whenever it wants the boundary moved by one more bit.

The whole block runs on the bit clock. The deserializer produces a word-boundary strobe, and that strobe stands in for the parallel clock: the request is sampled only at boundaries, edge-detected there, and counted there. The inserted delay wraps back to zero after it reaches a programmable rollover point between 1 and 11 bit-times. A status output shows when the count sits at that point. To let slipping visit every bit position of a word, set the rollover point at or above the deserialization factor.

Top module: `slip_word_aligner`

## Requirements
- R1: The effective word width F is `deser_factor` clamped to the range 1..10. `word_valid` pulses for one cycle once every F bit clocks, starting F cycles after reset is released. With each pulse, `par_word[F-1:0]` holds the last F selected bits, with the earliest bit in bit F-1, and all bits of `par_word` above F-1 are zero.
- R2: Each accepted rising edge of `align_req` adds exactly one bit-time to the inserted delay. Holding the request high causes no further slip.
- R3: `align_req` is sampled only on word-boundary cycles. A high that covers no boundary is ignored, and another slip needs a low sample at a boundary between two high samples.
- R4: A slip takes effect at the second word boundary at which `align_req` is sampled high. From the next bit onward, the stream reaches the deserializer delayed by one more bit. The first word that is entirely realigned is delivered at the boundary after that.
- R5: The effective rollover point P is `rollover_pt` clamped to the range 1..11. An accepted slip with an inserted delay below P increments the delay. An accepted slip with a delay at or above P returns it to zero.
- R6: `rollover_flag` is high exactly while the inserted delay equals P.
- R7: While `rst_n` is low, the inserted delay, the delay line, the word, `word_valid` and `rollover_flag` are all zero, and the boundary counter restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial receive bit, one per clock |
| deser_factor | input | 4 | Word width, clamped to 1..10 |
| rollover_pt | input | 4 | Maximum inserted delay, clamped to 1..11 |
| align_req | input | 1 | Slip request from the parallel side |
| par_word | output | 10 | Deserialized word, earliest bit in bit F-1 |
| word_valid | output | 1 | One-cycle pulse when par_word updates |
| rollover_flag | output | 1 | High while inserted delay equals the rollover point |

## Verification
The word capture and an accepted slip fall on the same boundary cycle. At that cycle the old delay selects the last bit of the captured word, and the new delay starts with the following bit. The bench provokes this collision with long pulses, held requests and sub-word glitches on `align_req`, using several word widths. It judges the result against a behavioural model that applies the old delay to the capture and then updates the count. The same collision at the rollover point, where the count wraps to zero and the flag drops, is covered with the clamped extremes of both configuration inputs.

// File: rtl/slip_align_pkg.sv
package slip_align_pkg;

  // Force a configuration value into [lo, hi].
  function automatic int clamp_range(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Inserted-delay step: wrap once the limit has been reached.
  function automatic int next_insert(input int cur, input int lim);
    return (cur >= lim) ? 0 : cur + 1;
  endfunction

  // Last bit index of a word of the given width.
  function automatic int last_index(input int width);
    return width - 1;
  endfunction

endpackage

// File: rtl/word_deser.sv
module word_deser #(
  parameter int MAX_FACTOR = 10,
  localparam int FW = $clog2(MAX_FACTOR + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FW-1:0]         factor,
  input  logic                  bit_in,
  output logic                  strobe,
  output logic [MAX_FACTOR-1:0] word,
  output logic                  valid
);
  logic [FW-1:0]         bit_cnt;
  logic [MAX_FACTOR-1:0] sh_q;
  logic [MAX_FACTOR-1:0] sh_nxt;
  logic [MAX_FACTOR-1:0] keep_mask;

  assign strobe = (int'(bit_cnt) >= slip_align_pkg::last_index(int'(factor)));
  assign sh_nxt = {sh_q[MAX_FACTOR-2:0], bit_in};

  for (genvar i = 0; i < MAX_FACTOR; i++) begin : g_mask
    assign keep_mask[i] = (i < int'(factor));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sh_q    <= '0;
      word    <= '0;
      valid   <= 1'b0;
    end else begin
      sh_q  <= sh_nxt;
      valid <= strobe;
      if (strobe) begin
        bit_cnt <= '0;
        word    <= sh_nxt & keep_mask;
      end else begin
        bit_cnt <= bit_cnt + FW'(1);
      end
    end
  end
endmodule

// File: rtl/align_req_edge.sv
module align_req_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic req_in,
  output logic slip_pulse
);
  logic smp_q;
  logic old_q;

  // Sampled at word boundaries only; a new high sample after a low one slips.
  assign slip_pulse = strobe & smp_q & ~old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
      old_q <= 1'b0;
    end else if (strobe) begin
      smp_q <= req_in;
      old_q <= smp_q;
    end
  end
endmodule

// File: rtl/slip_delay_line.sv
module slip_delay_line #(
  parameter int MAX_SLIP = 11,
  localparam int CW = $clog2(MAX_SLIP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_in,
  input  logic          slip_pulse,
  input  logic [CW-1:0] roll_lim,
  output logic          bit_out,
  output logic [CW-1:0] insert_cnt
);
  logic [MAX_SLIP-1:0] dly_q;

  always_comb begin
    bit_out = bit_in;
    for (int k = 1; k <= MAX_SLIP; k++) begin
      if (insert_cnt == CW'(k)) bit_out = dly_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q      <= '0;
      insert_cnt <= '0;
    end else begin
      dly_q <= {dly_q[MAX_SLIP-2:0], bit_in};
      if (slip_pulse)
        insert_cnt <= CW'(slip_align_pkg::next_insert(int'(insert_cnt), int'(roll_lim)));
    end
  end
endmodule

// File: rtl/slip_word_aligner.sv
module slip_word_aligner #(
  parameter int MAX_FACTOR = 10,
  parameter int MAX_SLIP   = 11,
  localparam int FW = $clog2(MAX_FACTOR + 1),
  localparam int CW = $clog2(MAX_SLIP + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_in,
  input  logic [FW-1:0]         deser_factor,
  input  logic [CW-1:0]         rollover_pt,
  input  logic                  align_req,
  output logic [MAX_FACTOR-1:0] par_word,
  output logic                  word_valid,
  output logic                  rollover_flag
);
  logic [FW-1:0] eff_factor;
  logic [CW-1:0] eff_roll;
  logic          word_strobe;
  logic          slip_pulse;
  logic          slipped_bit;
  logic [CW-1:0] insert_cnt;

  assign eff_factor = FW'(slip_align_pkg::clamp_range(int'(deser_factor), 1, MAX_FACTOR));
  assign eff_roll   = CW'(slip_align_pkg::clamp_range(int'(rollover_pt), 1, MAX_SLIP));

  align_req_edge req_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (word_strobe),
    .req_in     (align_req),
    .slip_pulse (slip_pulse)
  );

  slip_delay_line #(.MAX_SLIP(MAX_SLIP)) dly_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_in     (ser_in),
    .slip_pulse (slip_pulse),
    .roll_lim   (eff_roll),
    .bit_out    (slipped_bit),
    .insert_cnt (insert_cnt)
  );

  word_deser #(.MAX_FACTOR(MAX_FACTOR)) des_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .factor (eff_factor),
    .bit_in (slipped_bit),
    .strobe (word_strobe),
    .word   (par_word),
    .valid  (word_valid)
  );

  assign rollover_flag = (insert_cnt == eff_roll);
endmodule

// File: rtl/slip_word_aligner_chk.sv
module slip_word_aligner_chk #(
  parameter int FW = 4,
  parameter int CW = 4,
  parameter int MAX_SLIP = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          word_strobe,
  input logic          slip_pulse,
  input logic [CW-1:0] insert_cnt,
  input logic [CW-1:0] eff_roll,
  input logic [FW-1:0] eff_factor,
  input logic          word_valid,
  input logic          rollover_flag
);
  assert_valid_after_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(word_strobe));

  assert_valid_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && eff_factor > 1) |-> !word_strobe);

  assert_one_slip_per_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |=> !slip_pulse);

  assert_count_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !slip_pulse |=> $stable(insert_cnt));

  assert_slip_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_pulse && eff_factor > 1) |=> !word_strobe);

  assert_count_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_pulse && insert_cnt < eff_roll) |=> insert_cnt == CW'($past(insert_cnt) + 1'b1));

  assert_count_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_pulse && insert_cnt >= eff_roll) |=> insert_cnt == '0);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(insert_cnt) <= MAX_SLIP);

  assert_flag_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rollover_flag |-> insert_cnt != '0);
endmodule

bind slip_word_aligner slip_word_aligner_chk #(.FW(FW), .CW(CW), .MAX_SLIP(MAX_SLIP)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .word_strobe   (word_strobe),
  .slip_pulse    (slip_pulse),
  .insert_cnt    (insert_cnt),
  .eff_roll      (eff_roll),
  .eff_factor    (eff_factor),
  .word_valid    (word_valid),
  .rollover_flag (rollover_flag)
);

// File: tb/slip_word_aligner_tb.sv
module slip_word_aligner_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_in = 1'b0;
  logic [3:0] deser_factor = 4'd4;
  logic [3:0] rollover_pt = 4'd4;
  logic       align_req = 1'b0;
  logic [9:0] par_word;
  logic       word_valid;
  logic       rollover_flag;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  int m_bitcnt = 0;
  int m_slip = 0;
  int m_sh = 0;
  int m_word = 0;
  bit m_valid = 0;
  bit m_rq0 = 0;
  bit m_rq1 = 0;
  bit hist[$];
  int t = 0;
  logic [3:0] pat = 4'b1100;

  always #(CLK_PERIOD/2) clk = ~clk;

  slip_word_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .deser_factor(deser_factor),
    .rollover_pt(rollover_pt), .align_req(align_req), .par_word(par_word),
    .word_valid(word_valid), .rollover_flag(rollover_flag)
  );

  function automatic int clampi(int v, int lo, int hi);
    return v < lo ? lo : (v > hi ? hi : v);
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // Advance model and DUT by one clock, then compare all outputs.
  task automatic step();
    int f, rp, sel, shn;
    f = clampi(int'(deser_factor), 1, 10);
    rp = clampi(int'(rollover_pt), 1, 11);
    if (!rst_n) begin
      m_bitcnt = 0; m_slip = 0; m_sh = 0; m_word = 0; m_valid = 0;
      m_rq0 = 0; m_rq1 = 0; hist.delete();
    end else begin
      if (m_slip == 0) sel = ser_in;
      else sel = (m_slip - 1 < hist.size()) ? int'(hist[m_slip-1]) : 0;
      hist.push_front(ser_in);
      if (hist.size() > 16) void'(hist.pop_back());
      shn = ((m_sh << 1) | sel) & 'h3ff;
      if (m_bitcnt >= f - 1) begin
        m_word = shn & ((1 << f) - 1);
        m_valid = 1;
        if (m_rq0 && !m_rq1) m_slip = (m_slip >= rp) ? 0 : m_slip + 1;
        m_rq1 = m_rq0;
        m_rq0 = align_req;
        m_bitcnt = 0;
      end else begin
        m_valid = 0;
        m_bitcnt++;
      end
      m_sh = shn;
    end
    @(posedge clk);
    #1;
    check(int'(par_word) == m_word, "R1 par_word", int'(par_word), m_word);
    check(word_valid == m_valid, "R1 word_valid", int'(word_valid), int'(m_valid));
    check(rollover_flag == (m_slip == rp), "R6 rollover_flag", int'(rollover_flag), int'(m_slip == rp));
  endtask

  task automatic run_pat(input int n);
    for (int i = 0; i < n; i++) begin
      ser_in = pat[3 - (t % 4)];
      step();
      t++;
    end
  endtask

  task automatic run_to_valid();
    for (int i = 0; i < 40; i++) begin
      run_pat(1);
      if (word_valid) break;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    align_req = 1'b0;
    run_pat(3);
    rst_n = 1'b1;
    t = 0;
  endtask

  // request high across two boundaries, then low across two (factor 4)
  task automatic slip_once();
    align_req = 1'b1;
    run_pat(9);
    align_req = 1'b0;
    run_pat(9);
    run_to_valid();
    run_to_valid();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    // R7: reset state
    run_pat(3);
    check(par_word == 10'd0 && !word_valid && !rollover_flag, "R7 reset outputs", int'(par_word), 0);
    rst_n = 1'b1;
    t = 0;

    // R1: aligned words of width 4 from pattern 1100
    run_pat(12);
    run_to_valid();
    check(par_word == 10'b1100, "R1 unslipped word", int'(par_word), 'b1100);

    // R2/R4: one slip rotates the word by one bit
    slip_once();
    check(par_word == 10'b0110, "R4 word after one slip", int'(par_word), 'b0110);

    // R2: held request gives one slip only
    align_req = 1'b1;
    run_pat(48);
    check(par_word == 10'b0011, "R2 held request single slip", int'(par_word), 'b0011);
    align_req = 1'b0;
    run_pat(9);

    // R3: a one-cycle glitch away from a boundary is ignored
    while (m_bitcnt != 0) run_pat(1);
    align_req = 1'b1;
    run_pat(1);
    align_req = 1'b0;
    run_pat(16);
    run_to_valid();
    check(par_word == 10'b0011, "R3 glitch ignored", int'(par_word), 'b0011);

    // R5/R6: reach the rollover point, then wrap
    slip_once();
    check(par_word == 10'b1001 && !rollover_flag, "R5 third slip", int'(par_word), 'b1001);
    slip_once();
    check(rollover_flag == 1'b1, "R6 flag at rollover point", int'(rollover_flag), 1);
    check(par_word == 10'b1100, "R5 four-bit delay word", int'(par_word), 'b1100);
    slip_once();
    check(rollover_flag == 1'b0, "R5 flag clear after wrap", int'(rollover_flag), 0);
    check(par_word == 10'b1100, "R5 wrapped word", int'(par_word), 'b1100);

    // R7: reset mid-run clears the inserted delay
    slip_once();
    do_reset();
    run_pat(12);
    run_to_valid();
    check(par_word == 10'b1100, "R7 delay cleared by reset", int'(par_word), 'b1100);

    // R5: rollover point 0 clamps to 1
    rollover_pt = 4'd0;
    do_reset();
    run_pat(8);
    slip_once();
    check(rollover_flag == 1'b1, "R5 clamped rollover flag", int'(rollover_flag), 1);
    slip_once();
    check(rollover_flag == 1'b0, "R5 clamped rollover wrap", int'(rollover_flag), 0);

    // R1-style random traffic at wide and clamped factors, model compared every clock
    deser_factor = 4'd10; rollover_pt = 4'd15;
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      ser_in = 1'($urandom);
      if (i % 23 == 0) align_req = ~align_req;
      step();
    end
    deser_factor = 4'd0; rollover_pt = 4'd3;
    do_reset();
    for (int i = 0; i < 800; i++) begin
      ser_in = 1'($urandom);
      if (i % 5 == 0) align_req = 1'($urandom);
      step();
    end
    check(par_word[9:1] == 9'd0, "R1 clamped width-1 upper bits", int'(par_word), int'(par_word[0]));
    deser_factor = 4'd15; rollover_pt = 4'd11;
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      ser_in = 1'($urandom);
      if (i % 31 == 0) align_req = ~align_req;
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule